// File: doc/BRIEF.md
# Prescaled UART Baud Generator

This block derives bit timing for an asynchronous serial channel from the peripheral clock. Software loads two settings through a small register-write port. One is a 2-bit clock-select code that picks a coarse prescale of 1, 4, 16 or 64. The other is an 8-bit rate value N. The block emits a 16x oversampling strobe for a receiver and a one-per-bit strobe for a transmitter. The oversampling strobe repeats every 2 × prescale × (N+1) peripheral clocks, so one bit lasts 32 × prescale × (N+1) clocks.

The coarse stage is a single counter whose terminal value is set by the select code. It drives a reloadable counter that counts N+1 coarse steps, and a final divide-by-16 produces the bit strobe. A register write restarts all three stages, so the next strobe comes exactly one period after the write. An enable input holds the whole chain idle.

Top module: `prescaled_baud_gen`

## Requirements
- R1: A write with `wr_addr` = 0 loads the select code from `wr_data[1:0]`. Codes 0, 1, 2 and 3 give prescale 1, 4, 16 and 64. `wr_data[7:2]` has no effect on that write.
- R2: With select code s and rate N, consecutive `os_tick` pulses are exactly 2 × 4^s × (N+1) clock cycles apart. This holds for every code and for every N from 0 to 255, including both ends of that range.
- R3: `bit_tick` pulses on every 16th `os_tick`, in the same cycle as that `os_tick`, so bit ticks are 16 oversampling periods apart.
- R4: A register write restarts the timing. The first `os_tick` is high T cycles after the write's clock edge (T being the oversampling period), and the first `bit_tick` is high 16T cycles after it. No tick is high in the cycle that follows the write edge.
- R5: While `enable` is low, neither tick pulses and the count is held at its start. The first `os_tick` comes T cycles after the last edge at which `enable` was sampled low.
- R6: Each tick is a pulse one clock cycle wide.
- R7: Synchronous active-high reset clears both ticks, sets the select code to 0 and sets the rate to 0. After reset, with `enable` high, `os_tick` first comes 2 cycles after the last reset edge.
- R8: A write with `wr_addr` = 1 loads N from `wr_data[7:0]` and leaves the select code unchanged. Writes are accepted while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low holds the chain idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the clock-select code, 1 selects the rate value |
| wr_data | input | 8 | Write data |
| os_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | One strobe per bit period |

## Verification
The assertions check, on every cycle, the local rules: each tick is one cycle wide, every bit tick coincides with an oversampling tick, and no tick follows a write edge or a cycle with enable low. The spacing of the ticks can only be shown by the bench's scenarios, because it depends on the chosen code and rate. The bench measures the delay after a write and the repeat spacing for N = 0 and N = 255 under all four codes, plus random settings. It also covers the bit-tick period, restart after disable and writes made while disabled.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int SEL_W      = 2;
    localparam int RATE_W     = 8;
    localparam int OSR        = 16;
    localparam int PRE_MAXDIV = 2 * (4 ** ((2 ** SEL_W) - 1));
    localparam int PRE_CW     = $clog2(PRE_MAXDIV);

    typedef enum logic [SEL_W-1:0] {
        CS_DIV1  = 2'd0,
        CS_DIV4  = 2'd1,
        CS_DIV16 = 2'd2,
        CS_DIV64 = 2'd3
    } clk_sel_e;

    typedef enum logic {
        REG_MODE = 1'b0,
        REG_RATE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        clk_sel_e            sel;
        logic [RATE_W-1:0]   rate;
    } baud_cfg_t;

    // Terminal count of the coarse stage: it divides by 2 * 4^sel.
    function automatic logic [PRE_CW-1:0] pre_terminal(input clk_sel_e s);
        int div;
        div = 2 << (2 * int'(s));
        return PRE_CW'(div - 1);
    endfunction

endpackage

// File: rtl/bg_cfg_regs.sv
module bg_cfg_regs
    import baud_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [7:0]        wr_data,
    output baud_cfg_t         cfg,
    output logic              restart
);

    baud_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.sel  <= CS_DIV1;
            cfg_q.rate <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_addr) == REG_MODE) begin
                cfg_q.sel <= clk_sel_e'(wr_data[SEL_W-1:0]);
            end else begin
                cfg_q.rate <= wr_data[RATE_W-1:0];
            end
        end
    end

    assign cfg     = cfg_q;
    // Any write restarts the count so the new period begins at once.
    assign restart = wr_en;

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler
    import baud_gen_pkg::*;
(
    input  logic     clk,
    input  logic     clear,
    input  clk_sel_e sel,
    output logic     pre_step
);

    logic [PRE_CW-1:0] cnt_q;
    logic [PRE_CW-1:0] term;
    logic              at_term;

    assign term    = pre_terminal(sel);
    assign at_term = (cnt_q == term);

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
        end else if (at_term) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pre_step = at_term && !clear;

endmodule

// File: rtl/bg_reload_counter.sv
module bg_reload_counter
    import baud_gen_pkg::*;
#(
    parameter int CW = RATE_W
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          pre_step,
    input  logic [CW-1:0] reload,
    output logic          os_strobe,
    output logic          os_tick
);

    logic [CW-1:0] cnt_q;
    logic          os_q;
    logic          wrap;

    assign wrap      = (cnt_q == reload);
    assign os_strobe = pre_step && wrap;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
            os_q  <= 1'b0;
        end else begin
            os_q <= os_strobe;
            if (pre_step) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign os_tick = os_q;

endmodule

// File: rtl/bg_bit_divider.sv
module bg_bit_divider
    import baud_gen_pkg::*;
#(
    parameter int RATIO = OSR
) (
    input  logic clk,
    input  logic clear,
    input  logic os_strobe,
    output logic bit_tick
);

    localparam int BW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic bit_q;

    generate
        if (RATIO > 1) begin : g_count
            logic [BW-1:0] cnt_q;
            logic          last;

            assign last = (cnt_q == BW'(RATIO - 1));

            always_ff @(posedge clk) begin
                if (clear) begin
                    cnt_q <= '0;
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= os_strobe && last;
                    if (os_strobe) begin
                        cnt_q <= last ? '0 : cnt_q + 1'b1;
                    end
                end
            end
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (clear) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= os_strobe;
                end
            end
        end
    endgenerate

    assign bit_tick = bit_q;

endmodule

// File: rtl/prescaled_baud_gen.sv
module prescaled_baud_gen
    import baud_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic       os_tick,
    output logic       bit_tick
);

    baud_cfg_t cfg;
    logic      restart;
    logic      clear;
    logic      pre_step;
    logic      os_strobe;

    bg_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .restart (restart)
    );

    assign clear = rst || !enable || restart;

    bg_prescaler u_pre (
        .clk      (clk),
        .clear    (clear),
        .sel      (cfg.sel),
        .pre_step (pre_step)
    );

    bg_reload_counter #(.CW(RATE_W)) u_reload (
        .clk       (clk),
        .clear     (clear),
        .pre_step  (pre_step),
        .reload    (cfg.rate),
        .os_strobe (os_strobe),
        .os_tick   (os_tick)
    );

    bg_bit_divider #(.RATIO(OSR)) u_bits (
        .clk       (clk),
        .clear     (clear),
        .os_strobe (os_strobe),
        .bit_tick  (bit_tick)
    );

endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic wr_en,
    input logic os_tick,
    input logic bit_tick
);

    AST_OS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) os_tick |=> !os_tick); // R6
    AST_BIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) bit_tick |=> !bit_tick); // R6
    AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (rst) bit_tick |-> os_tick); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !enable |=> (!os_tick && !bit_tick)); // R5
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst) wr_en |=> (!os_tick && !bit_tick)); // R4

endmodule

bind prescaled_baud_gen baud_gen_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .wr_en    (wr_en),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/prescaled_baud_gen_tb_top.sv
module prescaled_baud_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       wr_en;
    logic       wr_addr;
    logic [7:0] wr_data;
    logic       os_tick;
    logic       bit_tick;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    prescaled_baud_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    function automatic int exp_period(input int sel, input int n);
        return 2 * (4 ** sel) * (n + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Counts clock edges until the chosen tick is seen high at a falling edge.
    task automatic count_to_tick(input bit want_bit, input int limit, output int k);
        k = 0;
        do begin
            @(posedge clk);
            k++;
            @(negedge clk);
        end while (!(want_bit ? bit_tick : os_tick) && k < limit);
    endtask

    task automatic program_and_time(input int sel, input int n, input string req, input bit spacing);
        int k;
        int t;
        t = exp_period(sel, n);
        wr(1'b0, 8'(sel));
        wr(1'b1, 8'(n));
        count_to_tick(1'b0, t + 8, k);
        check(k == t, {req, " first tick after write (R4)"}, k, t);
        if (spacing) begin
            count_to_tick(1'b0, t + 8, k);
            check(k == t, {req, " tick spacing (R2)"}, k, t);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int k;
        int t;
        int seen;
        int unsigned seed;
        rst = 1'b1; enable = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        seed = 32'h5EED;
        void'($urandom(seed));

        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!os_tick && !bit_tick, "R7 ticks low in reset", int'(os_tick) + int'(bit_tick), 0);
        rst = 1'b0;
        count_to_tick(1'b0, 20, k);
        check(k == 2, "R7 first tick after reset (code 0, N 0)", k, 2);
        count_to_tick(1'b0, 20, k);
        check(k == 2, "R2 default spacing", k, 2);

        // Both ends of the rate range at every code
        for (int s = 0; s < 4; s++) begin
            program_and_time(s, 0, "R2 N=0", 1'b1);
            program_and_time(s, 255, "R2 N=255", 1'b1);
        end

        // Bit tick timing
        wr(1'b0, 8'd1);
        wr(1'b1, 8'd3);
        t = exp_period(1, 3);
        count_to_tick(1'b1, 16 * t + 8, k);
        check(k == 16 * t, "R4 first bit tick after write", k, 16 * t);
        check(os_tick == 1'b1, "R3 bit tick coincides with os tick", int'(os_tick), 1);
        count_to_tick(1'b1, 16 * t + 8, k);
        check(k == 16 * t, "R3 bit tick spacing", k, 16 * t);
        @(posedge clk); @(negedge clk);
        check(!bit_tick && !os_tick, "R6 pulses one cycle wide", int'(bit_tick) + int'(os_tick), 0);

        // Upper select bits ignored
        wr(1'b0, 8'hFD);
        wr(1'b1, 8'd2);
        count_to_tick(1'b0, 40, k);
        check(k == exp_period(1, 2), "R1 upper mode bits ignored", k, exp_period(1, 2));

        // Rate write keeps the select code
        wr(1'b1, 8'd5);
        count_to_tick(1'b0, 80, k);
        check(k == exp_period(1, 5), "R8 rate write keeps code", k, exp_period(1, 5));

        // Disable holds everything quiet
        @(negedge clk);
        enable = 1'b0;
        seen = 0;
        repeat (300) begin
            @(posedge clk); @(negedge clk);
            if (os_tick || bit_tick) seen++;
        end
        check(seen == 0, "R5 no ticks while disabled", seen, 0);
        enable = 1'b1;
        count_to_tick(1'b0, 80, k);
        check(k == exp_period(1, 5), "R5 first tick after enable", k, exp_period(1, 5));

        // Writes accepted while disabled
        @(negedge clk);
        enable = 1'b0;
        wr(1'b0, 8'd2);
        wr(1'b1, 8'd1);
        @(negedge clk);
        enable = 1'b1;
        count_to_tick(1'b0, 80, k);
        check(k == exp_period(2, 1), "R8 write while disabled", k, exp_period(2, 1));

        // Random settings
        for (int i = 0; i < 6; i++) begin
            int s;
            int n;
            s = int'($urandom % 2);
            n = int'($urandom % 256);
            t = exp_period(s, n);
            program_and_time(s, n, "R2 random", 1'b0);
            @(posedge clk); @(negedge clk);
            check(!os_tick, "R6 random pulse width", int'(os_tick), 0);
            count_to_tick(1'b0, t + 8, k);
            check(k + 1 == t, "R2 random spacing", k + 1, t);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule